// File: doc/BRIEF.md
# I2C Master Read Length Controller

This block sits beside the bit-level shift engine of an I2C master. It decides how long a master read runs. Software writes a length word that holds an 8-bit count and an extend flag. The count is the wanted byte total minus one. For each received byte the shift engine gives a one-cycle strobe. The block counts the byte and stores it in a two-entry receive FIFO, which software drains through a read port. A running byte count is visible to software. The block raises a flag while the next byte is the final one, so the engine can NACK that byte and then request a STOP.

A read can be longer than 256 bytes. Software starts it with the extend flag set, and the read then runs with no end. After at least one wrap of the running count, software writes the length word again with the flag clear. The new count holds the remaining bytes minus one, and the read ends after that many further bytes. A byte that arrives while the FIFO is full is dropped, and a sticky flag records the loss.

Top module: `rx_len_ctrl`

## Requirements
- R1: After reset, cur_cnt, cfg_rdata and rd_data read 0, and last_byte, rx_done, rx_ovf and busy are low.
- R2: last_byte is high while busy is high, the extend flag (cfg_wdata[8]) is clear, and the bytes received since the last length write equal cfg_wdata[7:0]. A written count of 0 asks for exactly one byte.
- R3: cur_cnt[7:0] increments once per byte_vld strobe and wraps from 255 to 0, so a 256-byte read (count 255) ends with cur_cnt reading 0.
- R4: While the extend flag is set, last_byte stays low at any byte total. A length write during busy with the extend flag clear restarts only the remaining-length tally, and the read then ends after count+1 further bytes while cur_cnt keeps counting.
- R5: A length write while busy is low sets busy and zeroes both the received-byte tally and cur_cnt.
- R6: The FIFO holds two bytes. rd_data shows the oldest byte, and an rd_en pulse on a non-empty FIFO removes it. A byte that arrives on a full FIFO in the same cycle as an rd_en is accepted.
- R7: A byte that arrives on a full FIFO without an rd_en in the same cycle is dropped and sets rx_ovf. rx_ovf stays set until an ovf_clr pulse. A new overflow in the same cycle as ovf_clr takes priority.
- R8: rx_done is high for exactly one cycle, the cycle after the byte that was received while last_byte was high. busy is low from that cycle on.
- R9: rd_en on an empty FIFO leaves it empty, and rd_data keeps reading 0.
- R10: cfg_rdata shows the last written length word in bits [8:0]. Bits 15:9 of cfg_rdata, and bits 15:8 of rd_data and cur_cnt, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Length word write strobe |
| cfg_wdata | input | 9 | [8] extend flag, [7:0] byte count minus one |
| ovf_clr | input | 1 | Clears the overflow flag |
| byte_vld | input | 1 | Received-byte strobe from the shift engine |
| byte_data | input | 8 | Received byte |
| rd_en | input | 1 | Pops the oldest FIFO byte |
| rd_data | output | 16 | Oldest FIFO byte, zero-extended; 0 when empty |
| cfg_rdata | output | 16 | Length word readback, zero-extended |
| cur_cnt | output | 16 | Bytes received so far, modulo 256, zero-extended |
| last_byte | output | 1 | Next byte ends the read (NACK it) |
| rx_done | output | 1 | One-cycle pulse after the final byte |
| rx_ovf | output | 1 | Sticky FIFO overflow flag |
| busy | output | 1 | A read is in progress |

## Verification
An error in the remaining-length tally shows at the ports as last_byte rising one cycle early or late. It is visible in the same cycle the tally settles, before the engine could NACK the wrong byte. An error in the FIFO pointers or level shows in the next cycle, as a wrong byte or a wrong zero on rd_data, or as rx_ovf setting at the wrong moment. An error in the busy state or the done logic shows as a missing or doubled rx_done pulse. It also shows as a length write that zeroes cur_cnt when it should not. A reference model compared with every output on every clock catches each of these within one cycle.

// File: rtl/rx_len_pkg.sv
// Package rx_len_pkg
// Shared widths and the length-word layout for the read length controller.
package rx_len_pkg;
    localparam int BYTE_W     = 8;
    localparam int REG_W      = 16;
    localparam int FIFO_DEPTH = 2;

    // Length word: extend flag above an 8-bit count-minus-one field.
    typedef struct packed {
        logic              ext;
        logic [BYTE_W-1:0] cnt;
    } len_cfg_t;
endpackage

// File: rtl/rx_byte_fifo.sv
// Module rx_byte_fifo
// Small circular receive FIFO. A pop on a full FIFO frees room for a push
// in the same cycle. A push on a full FIFO with no pop is dropped and
// reported on drop. An empty FIFO reads zero.
// Assumes DEPTH is a power of two and at least 2.
module rx_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop_req,
    output logic [W-1:0] dout,
    output logic         drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] level;
    logic          empty, full, pop, push_ok;

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign pop     = pop_req && !empty;
    assign push_ok = push && (!full || pop);
    assign drop    = push && full && !pop;
    assign dout    = empty ? '0 : mem[rd_ptr];

    // Storage: write the accepted byte at the write pointer.
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[i] <= '0;
                else if (push_ok && wr_ptr == AW'(i))
                    mem[i] <= din;
            end
        end
    endgenerate

    // Pointers and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop)     rd_ptr <= rd_ptr + 1'b1;
            level <= level + LW'(push_ok) - LW'(pop);
        end
    end

    assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop_req) |=> (level == LW'(DEPTH)));
    assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !push) |=> ($stable(rd_ptr) && dout == '0));
endmodule

// File: rtl/rx_len_counter.sv
// Module rx_len_counter
// Holds the length word and the running byte count. It tracks the bytes
// received since the last length write and flags the final byte. A write
// while idle starts a read and zeroes both counts. A write during a read
// restarts only the remaining-length tally.
// Assumes byte_vld is a single-cycle strobe per byte.
module rx_len_counter
    import rx_len_pkg::*;
#(
    parameter int CW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  len_cfg_t      cfg_in,
    input  logic          byte_vld,
    output len_cfg_t      cfg_q,
    output logic [CW-1:0] cur_q,
    output logic          last_byte,
    output logic          done,
    output logic          active
);
    logic [CW-1:0] tally;
    logic          fin, idle_load;

    assign idle_load = cfg_wr && !active;
    assign last_byte = active && !cfg_q.ext && (tally == cfg_q.cnt);
    assign fin       = byte_vld && last_byte;

    // Length word register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= cfg_in;
    end

    // Running count: cleared by an idle load, else one step per byte.
    always_ff @(posedge clk) begin
        if (!rst_n || idle_load) cur_q <= '0;
        else if (byte_vld)       cur_q <= cur_q + 1'b1;
    end

    // Remaining-length tally: cleared by any length write.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_wr) tally <= '0;
        else if (byte_vld)    tally <= tally + 1'b1;
    end

    // Read state and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= fin;
            if (fin)         active <= 1'b0;
            else if (cfg_wr) active <= 1'b1;
        end
    end

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && last_byte) |=> (done && !active));
    assert_cur_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !idle_load) |=> (cur_q == $past(cur_q) + 1'b1));
    assert_idle_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        idle_load |=> (cur_q == '0 && active));
endmodule

// File: rtl/rx_len_ctrl.sv
// Module rx_len_ctrl
// Top of the read length controller. Joins the length counter and the
// receive FIFO, keeps the sticky overflow flag, and widens the register
// views to REG_W with zero upper bits.
// Assumes register strobes are one cycle wide.
module rx_len_ctrl
    import rx_len_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [BYTE_W:0]   cfg_wdata,
    input  logic              ovf_clr,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rd_data,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic [REG_W-1:0]  cur_cnt,
    output logic              last_byte,
    output logic              rx_done,
    output logic              rx_ovf,
    output logic              busy
);
    len_cfg_t          cfg_q;
    logic [BYTE_W-1:0] cur_q, fifo_dout;
    logic              drop;

    rx_len_counter #(.CW(BYTE_W)) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_in    (len_cfg_t'(cfg_wdata)),
        .byte_vld  (byte_vld),
        .cfg_q     (cfg_q),
        .cur_q     (cur_q),
        .last_byte (last_byte),
        .done      (rx_done),
        .active    (busy)
    );

    rx_byte_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (byte_vld),
        .din     (byte_data),
        .pop_req (rd_en),
        .dout    (fifo_dout),
        .drop    (drop)
    );

    // Sticky overflow: a new drop beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_ovf <= 1'b0;
        else if (drop)    rx_ovf <= 1'b1;
        else if (ovf_clr) rx_ovf <= 1'b0;
    end

    assign rd_data   = REG_W'(fifo_dout);
    assign cfg_rdata = REG_W'(cfg_q);
    assign cur_cnt   = REG_W'(cur_q);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovf && !ovf_clr) |=> rx_ovf);
endmodule

// File: tb/test_rx_len_ctrl.sv
module test_rx_len_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [8:0]  cfg_wdata = '0;
    logic        ovf_clr = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data, cfg_rdata, cur_cnt;
    logic        last_byte, rx_done, rx_ovf, busy;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_n = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rx_len_ctrl i_rx_len_ctrl (.*);

    // Reference model state
    logic [7:0] m_q[$];
    int m_cur, m_tally, m_cnt;
    bit m_ext, m_act, m_ovf, m_done;

    function automatic bit m_last();
        return m_act && !m_ext && (m_tally == m_cnt);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete(); m_cur = 0; m_tally = 0; m_cnt = 0;
            m_ext = 0; m_act = 0; m_ovf = 0; m_done = 0;
        end else begin
            bit pop, fin, drp;
            pop = rd_en && (m_q.size() > 0);
            fin = byte_vld && m_last();
            drp = byte_vld && (m_q.size() == 2) && !pop;
            if (pop) void'(m_q.pop_front());
            if (byte_vld && !drp) m_q.push_back(byte_data);
            m_ovf = drp ? 1'b1 : (ovf_clr ? 1'b0 : m_ovf);
            if (cfg_wr && !m_act) begin
                m_tally = 0; m_cur = 0; m_act = 1;
            end else begin
                if (byte_vld) m_cur = (m_cur + 1) % 256;
                if (cfg_wr) m_tally = 0;
                else if (byte_vld) m_tally = (m_tally + 1) % 256;
            end
            if (cfg_wr) begin m_cnt = cfg_wdata[7:0]; m_ext = cfg_wdata[8]; end
            if (fin) m_act = 0;
            m_done = fin;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc_n);
        end
    endtask

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int e_rd;
            e_rd = (m_q.size() > 0) ? int'(m_q[0]) : 0;
            chk(rd_data == 16'(e_rd), "R6 rd_data", rd_data, e_rd);
            chk(cur_cnt == 16'(m_cur), "R3 cur_cnt", cur_cnt, m_cur);
            chk(cfg_rdata == {7'd0, m_ext, 8'(m_cnt)}, "R10 cfg_rdata", cfg_rdata, {m_ext, 8'(m_cnt)});
            chk(last_byte == m_last(), m_ext ? "R4 last_byte" : "R2 last_byte", last_byte, m_last());
            chk(rx_done == m_done, "R8 rx_done", rx_done, m_done);
            chk(rx_ovf == m_ovf, "R7 rx_ovf", rx_ovf, m_ovf);
            chk(busy == m_act, "R5 busy", busy, m_act);
        end
    end

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 150000 && !finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc_n);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic cyc(input bit vld, input logic [7:0] d, input bit rd,
                       input bit wr, input logic [8:0] wd, input bit clr);
        @(negedge clk);
        byte_vld = vld; byte_data = d; rd_en = rd;
        cfg_wr = wr; cfg_wdata = wd; ovf_clr = clr;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr_len(input logic [8:0] wd);
        cyc(0, 0, 0, 1, wd, 0);
        idle();
    endtask

    // Receive one byte, then pop it.
    task automatic rx_pop(input logic [7:0] d);
        cyc(1, d, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1: reset state
        chk(cur_cnt == 0 && cfg_rdata == 0 && rd_data == 0, "R1 counts", cur_cnt, 0);
        chk(!last_byte && !rx_done && !rx_ovf && !busy, "R1 flags",
            {last_byte, rx_done, rx_ovf, busy}, 0);

        // R9: read while empty
        cyc(0, 0, 1, 0, 0, 0);
        idle();
        chk(rd_data == 0, "R9 empty read", rd_data, 0);

        // R2: three-byte read
        wr_len(9'd2);
        rx_pop(8'hA1); rx_pop(8'hB2);
        chk(last_byte == 1'b1, "R2 last before 3rd", last_byte, 1);
        cyc(1, 8'hC3, 0, 0, 0, 0);
        idle();
        chk(rx_done == 1'b1 && busy == 1'b0, "R8 done pulse", {rx_done, busy}, 2'b10);
        cyc(0, 0, 1, 0, 0, 0);
        chk(rx_done == 1'b0, "R8 single pulse", rx_done, 0);

        // R2: count 0 asks for one byte
        wr_len(9'd0);
        chk(last_byte == 1'b1 && cur_cnt == 0, "R2 one byte", last_byte, 1);
        rx_pop(8'h5A);

        // R6/R7: fill, overflow, pop with push, clear
        wr_len(9'd5);
        cyc(1, 8'h11, 0, 0, 0, 0);
        cyc(1, 8'h22, 0, 0, 0, 0);
        cyc(1, 8'h33, 0, 0, 0, 0);
        idle();
        chk(rx_ovf == 1'b1 && rd_data == 16'h11, "R7 drop on full", rd_data, 16'h11);
        cyc(1, 8'h44, 1, 0, 0, 0);
        idle();
        chk(rd_data == 16'h22 && rx_ovf, "R6 pop with push", rd_data, 16'h22);
        cyc(0, 0, 0, 0, 0, 1);
        idle();
        chk(rx_ovf == 1'b0, "R7 clear", rx_ovf, 0);
        cyc(0, 0, 1, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0);
        idle();
        rx_pop(8'h55); rx_pop(8'h66);
        chk(busy == 1'b0, "R8 ended after six", busy, 0);

        // R3: 256-byte read ends with cur_cnt at 0
        wr_len(9'h0FF);
        for (int i = 0; i < 256; i++) rx_pop(8'(i));
        chk(cur_cnt == 0 && busy == 0, "R3 wrap to 0", cur_cnt, 0);

        // R4: extended read of 305 bytes
        wr_len(9'h100);
        chk(cfg_rdata == 16'h0100, "R10 ext readback", cfg_rdata, 16'h0100);
        for (int i = 0; i < 300; i++) rx_pop(8'(i * 3));
        chk(busy == 1'b1 && last_byte == 1'b0, "R4 no end while extended", last_byte, 0);
        cyc(0, 0, 0, 1, 9'd4, 0);
        idle();
        chk(cur_cnt == 16'd44, "R4 reload keeps cur_cnt", cur_cnt, 44);
        for (int i = 0; i < 5; i++) rx_pop(8'hE0 + 8'(i));
        chk(cur_cnt == 16'd49 && busy == 0, "R4 ends after five", cur_cnt, 49);

        // R5: new idle write zeroes counts
        wr_len(9'h1AB);
        chk(cur_cnt == 0 && busy == 1 && cfg_rdata == 16'h01AB, "R5 idle load", cfg_rdata, 16'h01AB);
        idle();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule